// File: doc/BRIEF.md
# Debug Text Line Collector

This block gathers single bytes that software writes to a debug port and assembles them into text lines in a local byte store. Bytes can reach it through two bus windows: a fixed port window and a device I/O window. Each window carries a write strobe, an offset and an 8-bit value. Writes to any other offset in either window do nothing.

A line ends when a newline byte (0x0A) arrives, or when a byte arrives while the write position already sits on the last slot of the store. The byte that ends the line is never kept. In its place a zero terminator goes at the current position, a one-cycle flush pulse is raised together with the line length, and the write position returns to zero. The downstream sink reads the finished line through a synchronous read port and then acknowledges. Until it does, both windows hold off new bytes by dropping their ready signals.

Top module: `lb_line_collector`

## Requirements
- R1: After reset the write position is 0, no flush is pending, `flush_stb` is low and both ready outputs are high.
- R2: A byte other than 0x0A, accepted while the position is below DEPTH-1, is stored at the current position, the position advances by one, and no flush pulse follows.
- R3: An accepted 0x0A byte is not stored. On the next cycle `flush_stb` is high and `flush_len` equals the number of bytes stored in the line, and slot `flush_len` of the store holds 0x00.
- R4: A byte of any value accepted while the position equals DEPTH-1 is discarded. A flush follows with `flush_len` equal to DEPTH-1, and slot DEPTH-1 holds 0x00.
- R5: After every flush the position is 0, so the first byte of the next line lands in slot 0.
- R6: The fixed window accepts a byte only when `fx_we` is high with `fx_off` equal to 2. Writes at other offsets leave the line unchanged.
- R7: The I/O window accepts a byte only when `io_we` is high with `io_off` equal to 8. Writes at other offsets leave the line unchanged.
- R8: When both windows present a byte in the same cycle, the fixed-window byte is taken first and `io_rdy` is low. The I/O byte is taken in the next cycle, so it follows the fixed-window byte in the line.
- R9: From the flush pulse until the cycle after `flush_ack` is sampled high, both ready outputs are low. A byte held off in that time is accepted afterwards and is not lost.
- R10: `flush_stb` is high for exactly one cycle per flush.
- R11: `rd_data` shows the store content at `rd_addr` one clock after `rd_addr` is applied.
- R12: Asserting reset while a flush is pending cancels it, and both ready outputs return high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fx_we | input | 1 | Fixed-window byte write strobe |
| fx_off | input | FX_AW (4) | Fixed-window offset |
| fx_data | input | 8 | Fixed-window write byte |
| fx_rdy | output | 1 | Fixed-window ready; a write is taken when strobe and ready are high |
| io_we | input | 1 | I/O-window byte write strobe |
| io_off | input | IO_AW (8) | I/O-window offset |
| io_data | input | 8 | I/O-window write byte |
| io_rdy | output | 1 | I/O-window ready |
| flush_stb | output | 1 | One-cycle pulse marking a finished line |
| flush_len | output | OFF_W (12) | Length of the finished line, held until the next flush |
| flush_ack | input | 1 | Sink acknowledgement that frees the block for new bytes |
| rd_addr | input | OFF_W (12) | Sink read address |
| rd_data | output | 8 | Store byte at rd_addr, one cycle later |

## Verification
Two events can land on the same clock edge. One is a byte arriving from both windows at once. The other is a write arriving in the very cycle the sink acknowledges a flush. The bench drives both windows together on a hit offset and checks that only `io_rdy` drops. It then reads the line back to confirm that the fixed-window byte sits ahead of the I/O byte. For the second case it holds an I/O write through a pending flush and raises `flush_ack` with the write still present. It checks that the write is still refused on the acknowledge cycle, is taken on the following edge, and appears as the first byte of the next line.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t LB_NEWLINE = 8'h0A;
  localparam byte_t LB_TERM    = 8'h00;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FIX  = 2'd1,
    SRC_IO   = 2'd2
  } lb_src_e;
endpackage

// File: rtl/lb_ingress.sv
// Decodes the two bus windows and picks at most one byte per cycle.
module lb_ingress
  import lb_pkg::*;
#(
  parameter int FX_AW  = 4,
  parameter int IO_AW  = 8,
  parameter int FX_SEL = 2,
  parameter int IO_SEL = 8
) (
  input  logic             fx_we,
  input  logic [FX_AW-1:0] fx_off,
  input  byte_t            fx_data,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_off,
  input  byte_t            io_data,
  input  logic             busy,
  output logic             fx_rdy,
  output logic             io_rdy,
  output logic             take,
  output byte_t            take_data
);
  logic    fx_hit, io_hit;
  lb_src_e src;

  always_comb begin
    fx_hit = fx_we && (fx_off == FX_AW'(FX_SEL));
    io_hit = io_we && (io_off == IO_AW'(IO_SEL));
    fx_rdy = !busy;
    io_rdy = !busy && !fx_hit;
    if (busy)        src = SRC_NONE;
    else if (fx_hit) src = SRC_FIX;
    else if (io_hit) src = SRC_IO;
    else             src = SRC_NONE;
    take = (src != SRC_NONE);
    case (src)
      SRC_FIX: take_data = fx_data;
      SRC_IO:  take_data = io_data;
      default: take_data = LB_TERM;
    endcase
  end
endmodule

// File: rtl/lb_store.sv
// Byte store with one write port and a registered read port.
module lb_store
  import lb_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  byte_t         wdata,
  input  logic [AW-1:0] raddr,
  output byte_t         rdata
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lb_ctrl.sv
// Write position, flush decision and flush handshake.
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  byte_t         take_data,
  input  logic          ack,
  output logic          busy,
  output logic [AW-1:0] pos,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output byte_t         mem_wdata,
  output logic          stb,
  output logic [AW-1:0] len
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          end_line;
  logic [AW-1:0] pos_d, len_d;
  logic          busy_d, stb_d, pos_en, len_en;

  always_comb begin
    end_line  = take && ((take_data == LB_NEWLINE) || (pos == LAST));
    mem_we    = take;
    mem_addr  = pos;
    mem_wdata = end_line ? LB_TERM : take_data;
    pos_en    = take;
    pos_d     = end_line ? '0 : pos + AW'(1);
    len_en    = end_line;
    len_d     = pos;
    stb_d     = end_line;
    if (end_line)  busy_d = 1'b1;
    else if (ack)  busy_d = 1'b0;
    else           busy_d = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      busy <= 1'b0;
      stb  <= 1'b0;
      len  <= '0;
    end else begin
      if (pos_en) pos <= pos_d;
      if (len_en) len <= len_d;
      busy <= busy_d;
      stb  <= stb_d;
    end
  end
endmodule

// File: rtl/lb_line_collector.sv
module lb_line_collector
  import lb_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int FX_AW  = 4,
  parameter int IO_AW  = 8,
  parameter int FX_SEL = 2,
  parameter int IO_SEL = 8,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fx_we,
  input  logic [FX_AW-1:0] fx_off,
  input  logic [7:0]       fx_data,
  output logic             fx_rdy,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_off,
  input  logic [7:0]       io_data,
  output logic             io_rdy,
  output logic             flush_stb,
  output logic [OFF_W-1:0] flush_len,
  input  logic             flush_ack,
  input  logic [OFF_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);
  logic             take, busy, mem_we;
  byte_t            take_data, mem_wdata;
  logic [OFF_W-1:0] pos, mem_addr;

  lb_ingress #(
    .FX_AW(FX_AW), .IO_AW(IO_AW), .FX_SEL(FX_SEL), .IO_SEL(IO_SEL)
  ) u_ingress (
    .fx_we(fx_we), .fx_off(fx_off), .fx_data(fx_data),
    .io_we(io_we), .io_off(io_off), .io_data(io_data),
    .busy(busy), .fx_rdy(fx_rdy), .io_rdy(io_rdy),
    .take(take), .take_data(take_data)
  );

  lb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .take_data(take_data),
    .ack(flush_ack), .busy(busy), .pos(pos),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stb(flush_stb), .len(flush_len)
  );

  lb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/lb_line_collector_chk.sv
module lb_line_collector_chk #(
  parameter int DEPTH  = 4096,
  parameter int FX_AW  = 4,
  parameter int IO_AW  = 8,
  parameter int FX_SEL = 2,
  parameter int IO_SEL = 8,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fx_we,
  input logic [FX_AW-1:0] fx_off,
  input logic             fx_rdy,
  input logic             io_we,
  input logic [IO_AW-1:0] io_off,
  input logic             io_rdy,
  input logic             flush_stb,
  input logic [OFF_W-1:0] flush_len,
  input logic             take,
  input logic [7:0]       take_data,
  input logic [OFF_W-1:0] pos,
  input logic             busy
);
  logic fx_hit, io_hit;
  assign fx_hit = fx_we && (fx_off == FX_AW'(FX_SEL));
  assign io_hit = io_we && (io_off == IO_AW'(IO_SEL));

  a_r2_store_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_data != 8'h0A && pos != OFF_W'(DEPTH - 1))
      |=> (pos == $past(pos) + OFF_W'(1)) && !flush_stb);

  a_r3_newline_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_data == 8'h0A) |=> flush_stb && (flush_len == $past(pos)));

  a_r4_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pos == OFF_W'(DEPTH - 1))
      |=> flush_stb && (flush_len == OFF_W'(DEPTH - 1)));

  a_r5_pos_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flush_stb |-> (pos == '0));

  a_r8_fixed_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_hit && io_hit && fx_rdy) |-> !io_rdy);

  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!fx_rdy && !io_rdy && !take));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_stb |=> !flush_stb);
endmodule

bind lb_line_collector lb_line_collector_chk #(
  .DEPTH(DEPTH), .FX_AW(FX_AW), .IO_AW(IO_AW), .FX_SEL(FX_SEL), .IO_SEL(IO_SEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fx_we(fx_we), .fx_off(fx_off), .fx_rdy(fx_rdy),
  .io_we(io_we), .io_off(io_off), .io_rdy(io_rdy),
  .flush_stb(flush_stb), .flush_len(flush_len),
  .take(take), .take_data(take_data), .pos(pos), .busy(busy)
);

// File: tb/sim_lb_line_collector.sv
`timescale 1ns/1ps
module sim_lb_line_collector;
  localparam int DEPTH = 4096;
  localparam int OFF_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic fx_we, io_we, flush_ack;
  logic [3:0] fx_off;
  logic [7:0] io_off, fx_data, io_data, rd_data;
  logic fx_rdy, io_rdy, flush_stb;
  logic [OFF_W-1:0] flush_len, rd_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_line [DEPTH];
  int m_off = 0;

  always #10 clk = ~clk;

  lb_line_collector #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fx_we(fx_we), .fx_off(fx_off), .fx_data(fx_data), .fx_rdy(fx_rdy),
    .io_we(io_we), .io_off(io_off), .io_data(io_data), .io_rdy(io_rdy),
    .flush_stb(flush_stb), .flush_len(flush_len), .flush_ack(flush_ack),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] plain_byte();
    logic [7:0] b = 8'($urandom);
    return (b == 8'h0A) ? 8'h0B : b;
  endfunction

  // Reads back the finished line, then acknowledges (R11, R10, R9).
  task automatic drain_line();
    for (int i = 0; i <= m_off; i++) begin
      rd_addr = OFF_W'(i);
      @(negedge clk);
      if (i == 0) check(flush_stb == 1'b0, "R10 pulse width", int'(flush_stb), 0);
      check(rd_data == ((i == m_off) ? 8'h00 : exp_line[i]), "R11 line byte",
            int'(rd_data), int'((i == m_off) ? 8'h00 : exp_line[i]));
    end
    check(fx_rdy == 1'b0, "R9 held before ack", int'(fx_rdy), 0);
    flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
    #1;
    check(fx_rdy && io_rdy, "R9 ready after ack", int'(fx_rdy && io_rdy), 1);
    m_off = 0;
  endtask

  // Called on a negedge; returns on the negedge after the accepting edge.
  task automatic put(input bit use_io, input logic [7:0] d, input string tag);
    if (use_io) begin io_we = 1'b1; io_off = 8'd8; io_data = d; end
    else        begin fx_we = 1'b1; fx_off = 4'd2; fx_data = d; end
    #1;
    while (!(use_io ? io_rdy : fx_rdy)) begin @(negedge clk); #1; end
    @(negedge clk);
    io_we = 1'b0; fx_we = 1'b0;
    if (d == 8'h0A || m_off == DEPTH - 1) begin
      check(flush_stb == 1'b1, {tag, " flush pulse"}, int'(flush_stb), 1);
      check(flush_len == OFF_W'(m_off), {tag, " flush length"}, int'(flush_len), m_off);
      drain_line();
    end else begin
      check(flush_stb == 1'b0, "R2 no flush", int'(flush_stb), 0);
      exp_line[m_off] = d;
      m_off++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; fx_we = 1'b0; io_we = 1'b0; flush_ack = 1'b0;
    fx_off = '0; io_off = '0; fx_data = '0; io_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(fx_rdy && io_rdy, "R1 ready after reset", int'(fx_rdy && io_rdy), 1);
    check(flush_stb == 1'b0, "R1 no pulse after reset", int'(flush_stb), 0);
    @(negedge clk);

    // R3 empty line: length 0
    put(1'b0, 8'h0A, "R3");

    // R6 R7 non-hit offsets are ignored
    fx_we = 1'b1; fx_off = 4'd3; fx_data = 8'h55;
    io_we = 1'b1; io_off = 8'd2; io_data = 8'h66;
    @(negedge clk);
    fx_off = 4'd8; io_off = 8'd9;
    @(negedge clk);
    fx_we = 1'b0; io_we = 1'b0;
    put(1'b1, 8'h0A, "R6 R7");

    // R2 R3 random lines through both windows
    for (int ln = 0; ln < 25; ln++) begin
      int n = int'($urandom % 40);
      for (int k = 0; k < n; k++) put(1'($urandom), plain_byte(), "R2");
      put(1'($urandom), 8'h0A, "R3");
    end

    // R8 both windows in the same cycle
    put(1'b0, 8'h30, "R8");
    fx_we = 1'b1; fx_off = 4'd2; fx_data = 8'h31;
    io_we = 1'b1; io_off = 8'd8; io_data = 8'h32;
    #1;
    check(fx_rdy == 1'b1 && io_rdy == 1'b0, "R8 fixed wins", int'(io_rdy), 0);
    @(negedge clk);
    fx_we = 1'b0;
    #1;
    check(io_rdy == 1'b1, "R8 io taken next", int'(io_rdy), 1);
    @(negedge clk);
    io_we = 1'b0;
    exp_line[m_off] = 8'h31; m_off++;
    exp_line[m_off] = 8'h32; m_off++;
    put(1'b0, 8'h0A, "R8");

    // R9 write held through pending flush and ack cycle
    put(1'b0, 8'h41, "R9");
    fx_we = 1'b1; fx_off = 4'd2; fx_data = 8'h0A;
    @(negedge clk);
    fx_we = 1'b0;
    check(flush_stb && flush_len == OFF_W'(1), "R9 flush len", int'(flush_len), 1);
    io_we = 1'b1; io_off = 8'd8; io_data = 8'h42;
    for (int k = 0; k < 3; k++) begin
      #1; check(io_rdy == 1'b0, "R9 held", int'(io_rdy), 0);
      @(negedge clk);
    end
    flush_ack = 1'b1;
    #1; check(io_rdy == 1'b0, "R9 held in ack cycle", int'(io_rdy), 0);
    @(negedge clk);
    flush_ack = 1'b0;
    #1; check(io_rdy == 1'b1, "R9 released", int'(io_rdy), 1);
    @(negedge clk);
    io_we = 1'b0;
    m_off = 1; exp_line[0] = 8'h42;
    put(1'b1, 8'h0A, "R9");

    // R12 reset cancels a pending flush
    put(1'b0, 8'h51, "R12");
    fx_we = 1'b1; fx_off = 4'd2; fx_data = 8'h0A;
    @(negedge clk);
    fx_we = 1'b0;
    check(flush_stb == 1'b1, "R12 pending", int'(flush_stb), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(fx_rdy && io_rdy && !flush_stb, "R12 cancelled", int'(fx_rdy && io_rdy), 1);
    @(negedge clk);
    m_off = 0;
    put(1'b1, 8'h52, "R12");
    put(1'b0, 8'h0A, "R12");

    // R4 full store: trigger byte discarded, terminator at DEPTH-1
    for (int k = 0; k < DEPTH - 1; k++) put(1'($urandom), plain_byte(), "R2");
    put(1'b0, 8'h5A, "R4");

    // R5 next line starts at slot 0
    put(1'b1, 8'h61, "R5");
    put(1'b0, 8'h0A, "R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule